// File: doc/BRIEF.md
# Windowed Frequency Offset Estimator

This block estimates the residual carrier frequency offset in an asynchronous FSK receive path. It takes a stream of signed instantaneous-frequency samples, groups them into observation windows of a selectable number of bit periods, and at the end of each window publishes a new signed offset estimate. Two detectors are available. The mid-point detector keeps the largest and smallest sample of the window and reports the value halfway between them. The mean detector averages every sample of the window and suits DC-balanced (Manchester) data.

Two window-length codes are provided, one used before the receiver's gear switch and one used after it. A new estimate is withheld, and the previous one kept, when the receiver is frozen or when a run of identical bit decisions is longer than the window. In that case the mean or mid-point would only reflect one symbol level. Bit decisions are taken by comparing samples with the estimate currently in force. The controller is a three-state machine. `ST_IDLE` means no detector is selected. `ST_ACCUM` means a window is being collected. `ST_PUBLISH` is a one-cycle state in which the closed window's result is either written out or dropped. The transitions are:

- IDLE to ACCUM when a detector is selected.
- ACCUM to PUBLISH on the tick that closes a window.
- PUBLISH back to ACCUM.
- From ACCUM or PUBLISH to IDLE whenever the detector select becomes invalid.

Top module: `freq_offset_est`

## Requirements
- R1: After reset, `est_out` is 0, `est_upd` is 0 and `est_hold` is 0.
- R2: Window code c (0, 1, 2, 3) gives a window of 2, 4, 8 or 16 bit ticks. The window closes on the tick that completes the count. The outcome appears on the outputs one cycle after the state machine enters PUBLISH, which is two clock edges after the closing tick is sampled.
- R3: The window length comes from `win_code_post` when `gear_post` is high at the window's first bit tick, and from `win_code_pre` otherwise. That length is kept for the whole window.
- R4: With `mode_sel` = 3 (mid-point), the published estimate is floor((max + min) / 2) over the window's samples.
- R5: With `mode_sel` = 2 (mean), the published estimate is the window sample sum arithmetically shifted right by log2(samples per bit) + log2(window bits). The input is assumed to deliver exactly 2^SPB_LOG2 valid samples per bit.
- R6: With `mode_sel` = 0 or 1, no window is collected, `est_upd` stays low and `est_out` keeps its value.
- R7: A bit's symbol is 1 when the last valid sample of that bit is at or above the current `est_out`, and 0 otherwise. If the count of consecutive equal bit symbols exceeds the window's bit count at any tick of the window, that window's result is dropped. In that case `est_out` is unchanged, no strobe is given and `est_hold` goes to 1.
- R8: If `freeze` is high in the PUBLISH cycle, the result is dropped, `est_out` is kept and `est_hold` goes to 1.
- R9: `est_upd` is a single-cycle pulse. `est_out` changes only together with it, and `est_hold` is cleared whenever a result is published.
- R10: A sample presented in the same cycle as the closing tick belongs to the closing window. The next window starts with empty max, min and sum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_valid | input | 1 | Sample strobe |
| smp_data | input | SAMPLE_W | Signed instantaneous-frequency sample |
| bit_tick | input | 1 | Marks the last cycle of a bit period |
| mode_sel | input | 2 | 2 selects the mean detector, 3 the mid-point detector, other values idle |
| win_code_pre | input | 2 | Window code before the gear switch |
| win_code_post | input | 2 | Window code after the gear switch |
| gear_post | input | 1 | High once the gear switch has happened |
| freeze | input | 1 | Suppresses publishing while high |
| est_out | output | SAMPLE_W | Signed offset estimate |
| est_upd | output | 1 | One-cycle pulse when a new estimate is published |
| est_hold | output | 1 | High when the last closed window was dropped |

## Verification
Each hi-level bit carries a ramp of samples while each lo-level bit is flat. This makes the mid-point and mean results differ, so a design that swapped the two detectors or used the wrong shift would publish a wrong value. A design that used the pre-gear length despite the gear flag would publish after two bits instead of four.

A run that lasts exactly as long as the window must still publish, while a longer run must not. An off-by-one in the run comparison therefore either drops a valid window or passes a one-level window. Freeze, an idle mode select and the release of `est_hold` on the next good window are each checked at the outputs. A design that dropped the sample at the closing tick would lose the window maximum and report a lower mid-point.

// File: rtl/fo_pkg.sv
package fo_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_ACCUM   = 2'd1,
        ST_PUBLISH = 2'd2
    } fo_state_e;

    localparam logic [1:0] MODE_AVG = 2'd2;
    localparam logic [1:0] MODE_MID = 2'd3;

    localparam int RUN_W = 5;

    function automatic logic [RUN_W-1:0] win_len_bits(input logic [1:0] code);
        win_len_bits = RUN_W'(2) << code;
    endfunction

endpackage

// File: rtl/fo_accum.sv
module fo_accum #(
    parameter int SAMPLE_W = 12,
    parameter int SUM_W    = 20
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       clr,
    input  logic                       take,
    input  logic signed [SAMPLE_W-1:0] smp,
    input  logic                       close,
    output logic signed [SUM_W-1:0]    snap_sum,
    output logic signed [SAMPLE_W-1:0] snap_max,
    output logic signed [SAMPLE_W-1:0] snap_min
);

    logic signed [SUM_W-1:0]    sum_q, sum_n;
    logic signed [SAMPLE_W-1:0] max_q, max_n, min_q, min_n;
    logic                       have_q;
    logic signed [SUM_W-1:0]    smp_ext;

    assign smp_ext = {{(SUM_W-SAMPLE_W){smp[SAMPLE_W-1]}}, smp};

    always_comb begin
        sum_n = take ? (sum_q + smp_ext) : sum_q;
        max_n = max_q;
        min_n = min_q;
        if (take) begin
            if (!have_q || smp > max_q) max_n = smp;
            if (!have_q || smp < min_q) min_n = smp;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sum_q    <= '0;
            max_q    <= '0;
            min_q    <= '0;
            have_q   <= 1'b0;
            snap_sum <= '0;
            snap_max <= '0;
            snap_min <= '0;
        end else if (clr) begin
            sum_q  <= '0;
            have_q <= 1'b0;
        end else if (close) begin
            snap_sum <= sum_n;
            snap_max <= max_n;
            snap_min <= min_n;
            sum_q    <= '0;
            have_q   <= 1'b0;
        end else begin
            sum_q  <= sum_n;
            max_q  <= max_n;
            min_q  <= min_n;
            have_q <= have_q | take;
        end
    end

endmodule

// File: rtl/fo_runlen.sv
module fo_runlen #(
    parameter int SAMPLE_W = 12,
    parameter int RUN_W    = 5
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       smp_valid,
    input  logic signed [SAMPLE_W-1:0] smp,
    input  logic signed [SAMPLE_W-1:0] est,
    input  logic                       bit_tick,
    output logic [RUN_W-1:0]           run_next
);

    localparam logic [RUN_W-1:0] RUN_MAX = '1;

    logic             sym_q, prev_q, have_prev_q;
    logic             sym_now, bit_sym;
    logic [RUN_W-1:0] run_q;

    assign sym_now = (smp >= est);
    assign bit_sym = smp_valid ? sym_now : sym_q;

    always_comb begin
        if (have_prev_q && (bit_sym == prev_q))
            run_next = (run_q == RUN_MAX) ? run_q : run_q + RUN_W'(1);
        else
            run_next = RUN_W'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sym_q       <= 1'b0;
            prev_q      <= 1'b0;
            have_prev_q <= 1'b0;
            run_q       <= '0;
        end else begin
            if (smp_valid) sym_q <= sym_now;
            if (bit_tick) begin
                prev_q      <= bit_sym;
                have_prev_q <= 1'b1;
                run_q       <= run_next;
            end
        end
    end

endmodule

// File: rtl/fo_calc.sv
module fo_calc #(
    parameter int SAMPLE_W = 12,
    parameter int SUM_W    = 20,
    parameter int SPB_LOG2 = 3
) (
    input  logic [1:0]                 mode,
    input  logic [1:0]                 code,
    input  logic signed [SUM_W-1:0]    sum,
    input  logic signed [SAMPLE_W-1:0] mx,
    input  logic signed [SAMPLE_W-1:0] mn,
    output logic signed [SAMPLE_W-1:0] est_calc
);

    import fo_pkg::*;

    localparam int SH_W = 6;

    logic signed [SAMPLE_W:0]   mid_sum;
    logic signed [SAMPLE_W:0]   mid_half;
    logic signed [SUM_W-1:0]    avg_full;
    logic [SH_W-1:0]            shamt;

    assign mid_sum  = {mx[SAMPLE_W-1], mx} + {mn[SAMPLE_W-1], mn};
    assign mid_half = mid_sum >>> 1;
    assign shamt    = SH_W'(SPB_LOG2) + SH_W'(1) + SH_W'(code);
    assign avg_full = sum >>> shamt;

    always_comb begin
        if (mode == MODE_MID) est_calc = mid_half[SAMPLE_W-1:0];
        else                  est_calc = avg_full[SAMPLE_W-1:0];
    end

endmodule

// File: rtl/freq_offset_est.sv
module freq_offset_est #(
    parameter int SAMPLE_W = 12,
    parameter int SPB_LOG2 = 3
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       smp_valid,
    input  logic signed [SAMPLE_W-1:0] smp_data,
    input  logic                       bit_tick,
    input  logic [1:0]                 mode_sel,
    input  logic [1:0]                 win_code_pre,
    input  logic [1:0]                 win_code_post,
    input  logic                       gear_post,
    input  logic                       freeze,
    output logic signed [SAMPLE_W-1:0] est_out,
    output logic                       est_upd,
    output logic                       est_hold
);

    import fo_pkg::*;

    localparam int SUM_W = SAMPLE_W + SPB_LOG2 + 5;

    fo_state_e state_q, state_n;

    logic                       mode_ok, collect, win_end, run_over;
    logic [RUN_W-1:0]           win_cnt_q, cur_bits, run_next;
    logic [1:0]                 win_code_q, sel_code, cur_code;
    logic                       long_q, snap_long_q;
    logic [1:0]                 snap_mode_q, snap_code_q;
    logic signed [SUM_W-1:0]    snap_sum;
    logic signed [SAMPLE_W-1:0] snap_max, snap_min, est_calc;

    assign mode_ok  = (mode_sel == MODE_AVG) || (mode_sel == MODE_MID);
    assign collect  = (state_q != ST_IDLE) && mode_ok;
    assign sel_code = gear_post ? win_code_post : win_code_pre;
    assign cur_code = (win_cnt_q == '0) ? sel_code : win_code_q;
    assign cur_bits = win_len_bits(cur_code);
    assign win_end  = collect && bit_tick && ((win_cnt_q + RUN_W'(1)) == cur_bits);
    assign run_over = bit_tick && (run_next > cur_bits);

    fo_accum #(.SAMPLE_W(SAMPLE_W), .SUM_W(SUM_W)) i_accum (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (!collect),
        .take     (smp_valid && collect),
        .smp      (smp_data),
        .close    (win_end),
        .snap_sum (snap_sum),
        .snap_max (snap_max),
        .snap_min (snap_min)
    );

    fo_runlen #(.SAMPLE_W(SAMPLE_W), .RUN_W(RUN_W)) i_runlen (
        .clk       (clk),
        .rst_n     (rst_n),
        .smp_valid (smp_valid),
        .smp       (smp_data),
        .est       (est_out),
        .bit_tick  (bit_tick),
        .run_next  (run_next)
    );

    fo_calc #(.SAMPLE_W(SAMPLE_W), .SUM_W(SUM_W), .SPB_LOG2(SPB_LOG2)) i_calc (
        .mode     (snap_mode_q),
        .code     (snap_code_q),
        .sum      (snap_sum),
        .mx       (snap_max),
        .mn       (snap_min),
        .est_calc (est_calc)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_n;
    end

    // next-state logic
    always_comb begin
        state_n = state_q;
        unique case (state_q)
            ST_IDLE:    if (mode_ok) state_n = ST_ACCUM;
            ST_ACCUM: begin
                if (!mode_ok)     state_n = ST_IDLE;
                else if (win_end) state_n = ST_PUBLISH;
            end
            ST_PUBLISH: begin
                if (!mode_ok)     state_n = ST_IDLE;
                else if (win_end) state_n = ST_PUBLISH;
                else              state_n = ST_ACCUM;
            end
            default:    state_n = ST_IDLE;
        endcase
    end

    // window bookkeeping and snapshot of the closing window
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_cnt_q   <= '0;
            win_code_q  <= '0;
            long_q      <= 1'b0;
            snap_long_q <= 1'b0;
            snap_mode_q <= MODE_MID;
            snap_code_q <= '0;
        end else if (!collect) begin
            win_cnt_q <= '0;
            long_q    <= 1'b0;
        end else if (bit_tick) begin
            if (win_cnt_q == '0) win_code_q <= sel_code;
            if (win_end) begin
                win_cnt_q   <= '0;
                long_q      <= 1'b0;
                snap_long_q <= long_q | run_over;
                snap_mode_q <= mode_sel;
                snap_code_q <= cur_code;
            end else begin
                win_cnt_q <= win_cnt_q + RUN_W'(1);
                long_q    <= long_q | run_over;
            end
        end
    end

    // outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            est_out  <= '0;
            est_upd  <= 1'b0;
            est_hold <= 1'b0;
        end else begin
            est_upd <= 1'b0;
            if (state_q == ST_PUBLISH) begin
                if (freeze || snap_long_q) begin
                    est_hold <= 1'b1;
                end else begin
                    est_out  <= est_calc;
                    est_upd  <= 1'b1;
                    est_hold <= 1'b0;
                end
            end
        end
    end

endmodule

// File: rtl/fo_checker.sv
module fo_checker #(
    parameter int SAMPLE_W = 12
) (
    input logic                clk,
    input logic                rst_n,
    input logic [1:0]          mode_sel,
    input logic                freeze,
    input logic [SAMPLE_W-1:0] est_out,
    input logic                est_upd,
    input logic                est_hold
);

    a_r9_upd_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        est_upd |=> !est_upd);

    a_r9_est_moves_with_upd: assert property (@(posedge clk) disable iff (!rst_n)
        !est_upd |-> $stable(est_out));

    a_r9_hold_clear_on_upd: assert property (@(posedge clk) disable iff (!rst_n)
        est_upd |-> !est_hold);

    a_r8_freeze_blocks_upd: assert property (@(posedge clk) disable iff (!rst_n)
        freeze |=> !est_upd);

    a_r6_idle_mode_no_upd: assert property (@(posedge clk) disable iff (!rst_n)
        !($past(mode_sel, 2) inside {2'd2, 2'd3}) |-> !est_upd);

endmodule

bind freq_offset_est fo_checker #(.SAMPLE_W(SAMPLE_W)) i_fo_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode_sel (mode_sel),
    .freeze   (freeze),
    .est_out  (est_out),
    .est_upd  (est_upd),
    .est_hold (est_hold)
);

// File: tb/test_freq_offset_est.sv
module test_freq_offset_est;

    localparam int SAMPLE_W = 12;
    localparam int SPB      = 8;

    typedef struct packed {
        logic [1:0]         mode;
        logic [1:0]         code;
        logic signed [11:0] hi;
        logic signed [11:0] lo;
    } vec_t;

    // hi bits carry a ramp hi..hi+7, lo bits are flat; every vector publishes
    localparam vec_t VECS [6] = '{
        '{2'd3, 2'd0,  12'sd200, -12'sd200},
        '{2'd2, 2'd1,  12'sd300, -12'sd100},
        '{2'd3, 2'd2,  12'sd500, -12'sd300},
        '{2'd2, 2'd3,  12'sd400, -12'sd400},
        '{2'd3, 2'd3,  12'sd100, -12'sd1000},
        '{2'd2, 2'd0, -12'sd300, -12'sd900}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic smp_valid = 1'b0;
    logic signed [SAMPLE_W-1:0] smp_data = '0;
    logic bit_tick = 1'b0;
    logic [1:0] mode_sel = 2'd3;
    logic [1:0] win_code_pre = 2'd0;
    logic [1:0] win_code_post = 2'd0;
    logic gear_post = 1'b0;
    logic freeze = 1'b0;
    logic signed [SAMPLE_W-1:0] est_out;
    logic est_upd;
    logic est_hold;

    int n_vec = 0;
    int n_bad = 0;
    int upd_cnt = 0;
    int upd_base = 0;
    int m_sum = 0;
    int m_max = 0;
    int m_min = 0;
    bit m_have = 1'b0;

    always #4 clk = ~clk;

    freq_offset_est #(.SAMPLE_W(SAMPLE_W), .SPB_LOG2(3)) i_freq_offset_est (
        .clk           (clk),
        .rst_n         (rst_n),
        .smp_valid     (smp_valid),
        .smp_data      (smp_data),
        .bit_tick      (bit_tick),
        .mode_sel      (mode_sel),
        .win_code_pre  (win_code_pre),
        .win_code_post (win_code_post),
        .gear_post     (gear_post),
        .freeze        (freeze),
        .est_out       (est_out),
        .est_upd       (est_upd),
        .est_hold      (est_hold)
    );

    always @(posedge clk) if (rst_n && est_upd) upd_cnt <= upd_cnt + 1;

    task automatic check(input string req, input int act, input int exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic model_clear();
        m_sum = 0; m_max = 0; m_min = 0; m_have = 1'b0;
        upd_base = upd_cnt;
    endtask

    task automatic drive_bit(input int base, input bit ramp);
        for (int k = 0; k < SPB; k++) begin
            int v;
            v = base + (ramp ? k : 0);
            @(negedge clk);
            smp_valid = 1'b1;
            smp_data  = SAMPLE_W'(v);
            bit_tick  = (k == SPB - 1);
            m_sum = m_sum + v;
            if (!m_have || v > m_max) m_max = v;
            if (!m_have || v < m_min) m_min = v;
            m_have = 1'b1;
        end
    endtask

    task automatic end_drive();
        @(negedge clk);
        smp_valid = 1'b0;
        bit_tick  = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    // publishes: expected outcome; shift = SPB_LOG2 + log2(window bits)
    task automatic close_window(input string req, input bit publishes,
                                input logic [1:0] mode, input int shift,
                                input int prev_est);
        int exp_est;
        if (publishes) exp_est = (mode == 2'd3) ? ((m_max + m_min) >>> 1) : (m_sum >>> shift);
        else           exp_est = prev_est;
        check({req, " strobe count"}, upd_cnt - upd_base, publishes ? 1 : 0);
        check({req, " estimate"}, int'(est_out), exp_est);
        check({req, " hold flag"}, int'(est_hold), publishes ? 0 : 1);
        model_clear();
    endtask

    initial begin : watchdog
        repeat (60000) @(posedge clk);
        n_vec++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin : main
        int cur;
        repeat (5) @(negedge clk);
        // R1 reset state
        check("R1 est_out", int'(est_out), 0);
        check("R1 est_upd", int'(est_upd), 0);
        check("R1 est_hold", int'(est_hold), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        model_clear();

        // table walk: R2 window lengths, R4 mid-point, R5 mean, R10 closing sample
        for (int i = 0; i < 6; i++) begin
            int nbits;
            mode_sel     = VECS[i].mode;
            win_code_pre = VECS[i].code;
            repeat (2) @(negedge clk);
            model_clear();
            nbits = 2 << VECS[i].code;
            for (int b = 0; b < nbits / 2; b++) begin
                drive_bit(int'(VECS[i].hi), 1'b1);
                drive_bit(int'(VECS[i].lo), 1'b0);
            end
            end_drive();
            cur = int'(est_out);
            close_window((VECS[i].mode == 2'd3) ? "R2 R4 R10 mid window" : "R2 R5 R10 mean window",
                         1'b1, VECS[i].mode, 4 + int'(VECS[i].code), cur);
        end

        // R7 run equal to window length still publishes
        mode_sel = 2'd3; win_code_pre = 2'd0;
        repeat (2) @(negedge clk);
        model_clear();
        cur = int'(est_out);
        drive_bit(-100, 1'b1); drive_bit(-100, 1'b1);
        end_drive();
        close_window("R7 run equals window", 1'b1, 2'd3, 4, cur);

        // R7 run longer than window is dropped
        cur = int'(est_out);
        drive_bit(0, 1'b1); drive_bit(0, 1'b1);
        end_drive();
        close_window("R7 run exceeds window", 1'b0, 2'd3, 4, cur);

        // R9 next good window publishes and clears hold
        cur = int'(est_out);
        drive_bit(-500, 1'b0); drive_bit(0, 1'b1);
        end_drive();
        close_window("R9 hold release", 1'b1, 2'd3, 4, cur);

        // R8 freeze drops the result
        freeze = 1'b1;
        cur = int'(est_out);
        drive_bit(-800, 1'b0); drive_bit(100, 1'b1);
        end_drive();
        close_window("R8 freeze", 1'b0, 2'd3, 4, cur);
        freeze = 1'b0;
        repeat (2) @(negedge clk);

        // R3 gear flag selects the post-gear window (4 bits, not 2)
        win_code_pre = 2'd0; win_code_post = 2'd1; gear_post = 1'b1;
        model_clear();
        cur = int'(est_out);
        drive_bit(-600, 1'b0); drive_bit(300, 1'b1);
        end_drive();
        check("R3 no strobe after two bits", upd_cnt - upd_base, 0);
        check("R3 estimate kept after two bits", int'(est_out), cur);
        drive_bit(-600, 1'b0); drive_bit(300, 1'b1);
        end_drive();
        close_window("R3 post-gear window", 1'b1, 2'd3, 5, cur);
        gear_post = 1'b0;

        // R6 idle mode select: nothing collected, nothing published
        mode_sel = 2'd0;
        repeat (2) @(negedge clk);
        model_clear();
        cur = int'(est_out);
        drive_bit(-900, 1'b0); drive_bit(900, 1'b1);
        end_drive();
        check("R6 no strobe", upd_cnt - upd_base, 0);
        check("R6 estimate kept", int'(est_out), cur);

        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule